// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This unit computes the memory address for the load and store instructions of a small 32-bit RISC-style processor. The decode stage gives it a mode code, an access size, the value of a pointer register and its index, a second register value and a 16-bit immediate. The unit returns the effective address with a one-cycle valid strobe. For the auto-modify modes it also returns a register update: the register index, the new pointer value and a write enable.

Five of the modes finish one clock edge after the request is accepted. These are register direct, absolute, base plus signed displacement, post-increment and pre-decrement. The register file has a single write port. For this reason the pointer update of the auto-modify modes is issued in the cycle after the address, as a separate writeback. Push and pop on the stack pointer use these two modes.

The scaled-index mode adds a base register to the product of an index register and an unsigned 16-bit scale. The product is built by an iterative shift-and-add multiplier, and the address is ready after six clock edges. While a multi-cycle operation is in progress, the unit raises busy and ignores new requests.

Top module: `ea_unit`

## Requirements
- R1: Mode code 0 (register direct) gives EA equal to the base register value. The valid strobe is high in the cycle after the accepting clock edge.
- R2: Mode code 1 (absolute) gives EA equal to the 16-bit immediate, zero-extended. It completes with the same single-edge timing.
- R3: Mode code 2 (displacement) gives EA equal to the base value plus the immediate, sign-extended to 32 bits. It completes with single-edge timing.
- R4: Mode code 3 (post-increment) gives EA equal to the unmodified base value. The new pointer value is the base plus the step.
- R5: Mode code 4 (pre-decrement) gives EA equal to the base minus the step. The writeback value is the same number.
- R6: The step comes from the size code: 0 gives 1 (byte), 1 gives 2 (16-bit), 2 gives 4 (32-bit). The reserved code 3 also gives 4.
- R7: Mode code 5 (scaled index) gives EA = base + index × zero-extended scale, unsigned and taken modulo 2^32. The valid strobe rises after exactly six clock edges, counting the accepting edge as the first.
- R8: Busy is high from the accepting edge until the operation completes. For the auto-modify modes, completion is the writeback edge. Requests presented while busy is high are ignored: they produce no valid strobe and do not change the result.
- R9: An auto-modify request whose pointer index is 0 still produces its EA. It never asserts the write enable and does not raise busy.
- R10: All address arithmetic wraps modulo 2^32 without any indication.
- R11: Mode codes 6 and 7 are reserved. They produce no valid strobe, no write enable and no busy.
- R12: For an auto-modify request, the write enable pulses for exactly one cycle, in the cycle directly after the EA valid strobe. It carries the pointer index and the new pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe, taken when busy is low |
| mode_i | input | 3 | Addressing mode code |
| size_i | input | 2 | Access size code (0 byte, 1 16-bit, 2 and 3 32-bit) |
| ptr_idx_i | input | 5 | Index of the register that supplies base_i |
| base_i | input | 32 | Base or pointer register value |
| index_i | input | 32 | Index register value for scaled mode |
| imm_i | input | 16 | Immediate: address, displacement or scale |
| ea_o | output | 32 | Effective address, held until the next result |
| ea_valid_o | output | 1 | One-cycle strobe, ea_o is new |
| busy_o | output | 1 | Operation in progress, requests ignored |
| wb_en_o | output | 1 | Pointer writeback enable |
| wb_idx_o | output | 5 | Register index for the writeback |
| wb_val_o | output | 32 | Updated pointer value |

## Verification
The embedded assertions check, on every cycle, the ordering of the writeback pulse against the address strobe. They also check that no write is ever aimed at register 0, that busy has dropped by the writeback cycle, and that the multiplier's step counter stays within bounds and that its completion flag is a single pulse. The arithmetic results cannot be checked this way. These are the step for each size code, displacement sign extension, wrap-around, and the scaled product together with its exact six-edge latency. The same holds for the rule that requests made while busy are ignored and for the silence of the reserved codes. Only the bench's directed scenarios show these, by comparing against values computed from the requirements.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [2:0] {
    MODE_REG    = 3'd0,
    MODE_ABS    = 3'd1,
    MODE_DISP   = 3'd2,
    MODE_POSTI  = 3'd3,
    MODE_PRED   = 3'd4,
    MODE_SCALED = 3'd5
  } ea_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_MUL  = 2'd2
  } ea_state_e;

  // step in bytes for a size code; code 3 saturates at 4
  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      2'd0:    size_step = 3'd1;
      2'd1:    size_step = 3'd2;
      default: size_step = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/ea_direct_calc.sv
module ea_direct_calc
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [2:0]        mode_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic [ADDR_W-1:0] ptr_o
);

  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] imm_zext;
  logic [ADDR_W-1:0] imm_sext;
  logic [ADDR_W-1:0] inc_val;
  logic [ADDR_W-1:0] dec_val;

  assign step     = {{(ADDR_W-3){1'b0}}, size_step(size_i)};
  assign imm_zext = {{EXT_W{1'b0}}, imm_i};
  assign imm_sext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign inc_val  = base_i + step;
  assign dec_val  = base_i - step;

  always_comb begin
    ea_o  = base_i;
    ptr_o = base_i;
    case (ea_mode_e'(mode_i))
      MODE_REG:   ea_o = base_i;
      MODE_ABS:   ea_o = imm_zext;
      MODE_DISP:  ea_o = base_i + imm_sext;
      MODE_POSTI: begin
        ea_o  = base_i;
        ptr_o = inc_val;
      end
      MODE_PRED:  begin
        ea_o  = dec_val;
        ptr_o = dec_val;
      end
      default:    ea_o = base_i;
    endcase
  end

endmodule

// File: rtl/ea_scaled_mul.sv
module ea_scaled_mul #(
  parameter int ADDR_W  = 32,
  parameter int SCALE_W = 16,
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W-1:0]  index_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               done_o,
  output logic [ADDR_W-1:0]  result_o
);

  localparam int STEPS = SCALE_W / DIGIT_W;
  localparam int CNT_W = $clog2(STEPS + 1);

  logic               run;
  logic [CNT_W-1:0]   cnt;
  logic [ADDR_W-1:0]  acc;
  logic [ADDR_W-1:0]  mcand;
  logic [SCALE_W-1:0] mplier;
  logic [ADDR_W-1:0]  partial;

  // one digit of the scale times the shifted multiplicand
  always_comb begin
    partial = '0;
    for (int j = 0; j < DIGIT_W; j++) begin
      if (mplier[j]) partial = partial + (mcand << j);
    end
  end

  assign done_o   = run && (cnt == CNT_W'(STEPS));
  assign result_o = acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      cnt    <= '0;
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
    end else if (!run) begin
      if (start_i) begin
        run    <= 1'b1;
        cnt    <= '0;
        acc    <= base_i;
        mcand  <= index_i;
        mplier <= scale_i;
      end
    end else if (cnt != CNT_W'(STEPS)) begin
      acc    <= acc + partial;
      mcand  <= mcand << DIGIT_W;
      mplier <= mplier >> DIGIT_W;
      cnt    <= cnt + 1'b1;
    end else begin
      run <= 1'b0;
    end
  end

  // R7
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= CNT_W'(STEPS)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IMM_W   = 16,
  parameter int REG_W   = 5,
  parameter int DIGIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [2:0]        mode_i,
  input  logic [1:0]        size_i,
  input  logic [REG_W-1:0]  ptr_idx_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              ea_valid_o,
  output logic              busy_o,
  output logic              wb_en_o,
  output logic [REG_W-1:0]  wb_idx_o,
  output logic [ADDR_W-1:0] wb_val_o
);

  ea_state_e         state;
  logic              accept;
  logic              mul_start;
  logic              mul_done;
  logic [ADDR_W-1:0] mul_res;
  logic [ADDR_W-1:0] calc_ea;
  logic [ADDR_W-1:0] calc_ptr;

  assign accept    = req_i && (state == ST_IDLE);
  assign mul_start = accept && (mode_i == MODE_SCALED);
  assign busy_o    = (state != ST_IDLE);

  ea_direct_calc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) i_calc (
    .mode_i (mode_i),
    .size_i (size_i),
    .base_i (base_i),
    .imm_i  (imm_i),
    .ea_o   (calc_ea),
    .ptr_o  (calc_ptr)
  );

  ea_scaled_mul #(.ADDR_W(ADDR_W), .SCALE_W(IMM_W), .DIGIT_W(DIGIT_W)) i_mul (
    .clk      (clk),
    .rst      (rst),
    .start_i  (mul_start),
    .base_i   (base_i),
    .index_i  (index_i),
    .scale_i  (imm_i),
    .done_o   (mul_done),
    .result_o (mul_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ea_o       <= '0;
      ea_valid_o <= 1'b0;
      wb_en_o    <= 1'b0;
      wb_idx_o   <= '0;
      wb_val_o   <= '0;
    end else begin
      ea_valid_o <= 1'b0;
      wb_en_o    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_i) begin
            case (ea_mode_e'(mode_i))
              MODE_REG, MODE_ABS, MODE_DISP: begin
                ea_o       <= calc_ea;
                ea_valid_o <= 1'b1;
              end
              MODE_POSTI, MODE_PRED: begin
                ea_o       <= calc_ea;
                ea_valid_o <= 1'b1;
                if (ptr_idx_i != '0) begin
                  wb_idx_o <= ptr_idx_i;
                  wb_val_o <= calc_ptr;
                  state    <= ST_WB;
                end
              end
              MODE_SCALED: state <= ST_MUL;
              default: ;
            endcase
          end
        end
        ST_WB: begin
          wb_en_o <= 1'b1;
          state   <= ST_IDLE;
        end
        ST_MUL: begin
          if (mul_done) begin
            ea_o       <= mul_res;
            ea_valid_o <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12
  wb_after_ea_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> $past(ea_valid_o));

  // R12
  wb_single_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |=> !wb_en_o);

  // R9
  wb_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> (wb_idx_o != '0));

  // R8
  wb_idle_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> !busy_o);

endmodule

// File: tb/test_ea_unit.sv
module test_ea_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_i;
  logic [2:0]  mode_i;
  logic [1:0]  size_i;
  logic [4:0]  ptr_idx_i;
  logic [31:0] base_i;
  logic [31:0] index_i;
  logic [15:0] imm_i;
  logic [31:0] ea_o;
  logic        ea_valid_o;
  logic        busy_o;
  logic        wb_en_o;
  logic [4:0]  wb_idx_o;
  logic [31:0] wb_val_o;

  int checks   = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  ea_unit i_ea_unit (
    .clk(clk), .rst(rst), .req_i(req_i), .mode_i(mode_i), .size_i(size_i),
    .ptr_idx_i(ptr_idx_i), .base_i(base_i), .index_i(index_i), .imm_i(imm_i),
    .ea_o(ea_o), .ea_valid_o(ea_valid_o), .busy_o(busy_o),
    .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_val_o(wb_val_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, hold over one rising edge, return at the next falling edge
  task automatic issue(input logic [2:0] m, input logic [1:0] s, input logic [4:0] p,
                       input logic [31:0] b, input logic [31:0] x, input logic [15:0] im);
    @(negedge clk);
    req_i = 1'b1; mode_i = m; size_i = s; ptr_idx_i = p;
    base_i = b; index_i = x; imm_i = im;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic single(input string req, input logic [2:0] m, input logic [31:0] b,
                        input logic [15:0] im, input logic [31:0] exp);
    issue(m, 2'd0, 5'd3, b, 32'd0, im);
    check({req, " valid"}, 32'(ea_valid_o), 32'd1);
    check({req, " ea"}, ea_o, exp);
    check({req, " busy"}, 32'(busy_o), 32'd0);
  endtask

  function automatic logic [31:0] stepv(input logic [1:0] s);
    return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  task automatic automod(input string req, input logic pre, input logic [1:0] s,
                         input logic [4:0] p, input logic [31:0] b);
    logic [31:0] nv;
    nv = pre ? b - stepv(s) : b + stepv(s);
    issue(pre ? 3'd4 : 3'd3, s, p, b, 32'd0, 16'd0);
    check({req, " ea valid"}, 32'(ea_valid_o), 32'd1);
    check({req, " ea"}, ea_o, pre ? nv : b);
    check({req, " no wb with ea"}, 32'(wb_en_o), 32'd0);
    check({req, " R8 busy"}, 32'(busy_o), (p != 0) ? 32'd1 : 32'd0);
    @(negedge clk);
    check({req, " R12 wb_en"}, 32'(wb_en_o), (p != 0) ? 32'd1 : 32'd0);
    if (p != 0) begin
      check({req, " R12 wb idx"}, 32'(wb_idx_o), 32'(p));
      check({req, " wb val"}, wb_val_o, nv);
    end
    check({req, " busy cleared"}, 32'(busy_o), 32'd0);
    @(negedge clk);
    check({req, " R12 wb single"}, 32'(wb_en_o), 32'd0);
  endtask

  task automatic scaled(input string req, input logic [31:0] b, input logic [31:0] x,
                        input logic [15:0] sc, input logic intrude);
    logic [31:0] exp;
    exp = b + x * {16'd0, sc};
    issue(3'd5, 2'd0, 5'd2, b, x, sc);
    for (int k = 1; k <= 5; k++) begin
      check({req, " R7 early valid"}, 32'(ea_valid_o), 32'd0);
      check({req, " R8 busy"}, 32'(busy_o), 32'd1);
      if (intrude && k == 2) begin
        req_i = 1'b1; mode_i = 3'd0; base_i = 32'hDEAD0000;
      end else begin
        req_i = 1'b0;
      end
      @(negedge clk);
    end
    req_i = 1'b0;
    check({req, " R7 valid at edge 6"}, 32'(ea_valid_o), 32'd1);
    check({req, " R7 ea"}, ea_o, exp);
    @(negedge clk);
    check({req, " R8 no extra valid"}, 32'(ea_valid_o), 32'd0);
    check({req, " R8 idle"}, 32'(busy_o), 32'd0);
  endtask

  task automatic reserved(input logic [2:0] m);
    issue(m, 2'd2, 5'd4, 32'h1000, 32'd1, 16'd1);
    for (int k = 0; k < 3; k++) begin
      check("R11 no valid", 32'(ea_valid_o), 32'd0);
      check("R11 no wb", 32'(wb_en_o), 32'd0);
      check("R11 no busy", 32'(busy_o), 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; req_i = 1'b0; mode_i = '0; size_i = '0; ptr_idx_i = '0;
    base_i = '0; index_i = '0; imm_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("reset valid", 32'(ea_valid_o), 32'd0);
    check("reset busy", 32'(busy_o), 32'd0);
    check("reset wb_en", 32'(wb_en_o), 32'd0);

    single("R1 reg", 3'd0, 32'h1234_5678, 16'hFFFF, 32'h1234_5678);
    single("R2 abs", 3'd1, 32'hAAAA_AAAA, 16'hF00D, 32'h0000_F00D);
    single("R3 disp pos", 3'd2, 32'h0000_1000, 16'h0010, 32'h0000_1010);
    single("R3 disp neg", 3'd2, 32'h0000_1000, 16'hFFF0, 32'h0000_0FF0);
    single("R10 disp wrap", 3'd2, 32'hFFFF_FFF0, 16'h0020, 32'h0000_0010);

    automod("R4 R6 post byte", 1'b0, 2'd0, 5'd1, 32'h0000_0100);
    automod("R4 R6 post half", 1'b0, 2'd1, 5'd7, 32'h0000_0100);
    automod("R4 R6 post word", 1'b0, 2'd2, 5'd1, 32'h0000_0100);
    automod("R5 R6 pre byte", 1'b1, 2'd0, 5'd1, 32'h0000_0200);
    automod("R5 R6 pre half", 1'b1, 2'd1, 5'd9, 32'h0000_0200);
    automod("R5 R6 pre code3", 1'b1, 2'd3, 5'd1, 32'h0000_0200);
    automod("R10 post wrap", 1'b0, 2'd2, 5'd5, 32'hFFFF_FFFE);
    automod("R10 pre wrap", 1'b1, 2'd2, 5'd5, 32'h0000_0000);
    automod("R9 post r0", 1'b0, 2'd2, 5'd0, 32'h0000_0040);
    automod("R9 pre r0", 1'b1, 2'd1, 5'd0, 32'h0000_0040);

    scaled("R7 small", 32'h0000_0100, 32'd3, 16'h0010, 1'b0);
    scaled("R7 R10 wrap", 32'd5, 32'hFFFF_FFFF, 16'hFFFF, 1'b0);
    scaled("R8 ignore", 32'h0001_0000, 32'd7, 16'h1234, 1'b1);

    reserved(3'd6);
    reserved(3'd7);

    single("R1 back to idle", 3'd0, 32'h0BAD_F00D, 16'h0, 32'h0BAD_F00D);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule